// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This block drives one pulse-width-modulated pin per channel (two channels by default) from a small register file written over a plain register bus. A shared control word gives each channel an eight-bit lane. The lane holds a divider code, a run-enable bit, an output-sense bit, a counter gate bit and a clock pass-through bit. Each channel also owns a second word that holds its period count in the upper half and its active count in the lower half. Every register reads back on the same bus.

A channel divides the source clock by the selected ratio and steps a counter from zero to the period count minus one. While the counter is below the active count, the output sits at its active level. Period and active-count updates are taken only at period boundaries. Divider changes are taken only while the gate bit is low. Setting the pass-through bit routes the source clock itself to the pin, whatever the other bits say. The bus is a register interface with no data stream, so it has no handshake. A write lands on the clock edge where `bus_we_i` is high, and a read is combinational from `bus_addr_i`.

Top module: `pwm_multi`

## Requirements
- R1: After reset every register reads zero and every pin sits at 1, which is the inactive level of the inverted sense that an all-zero lane selects.
- R2: Address 0 holds the control word, with channel n in bits [8n+7:8n]. Within a lane, bits [3:0] are the divider code, bit 4 is enable, bit 5 is the output sense, bit 6 is the gate and bit 7 is pass-through. Address 1+n holds channel n's period in bits [31:16] and its active count in bits [15:0]. Each register reads back the last value written to it, and other addresses read zero.
- R3: A running channel repeats a cycle of divider × period source clocks. Its output is active for the first divider × active-count clocks of that cycle.
- R4: Divider code c in 0..7 divides by 2^(c+1), and code 15 divides by 1. Codes 8..14 are invalid: with such a code the channel does not count and its output stays inactive.
- R5: With the sense bit at 1 the active level is high. With the sense bit at 0 the active level is low and the inactive level is high.
- R6: A channel counts only while both enable and gate are 1. Otherwise its output is inactive, and its next run starts from the beginning of a cycle.
- R7: A divider code written while the gate is 1 has no effect until the gate has been 0 for at least one clock.
- R8: Period and active-count writes made while a channel runs take effect only at the end of the cycle in progress.
- R9: An active count greater than or equal to the period holds the output active for the whole cycle, and an active count of zero holds it inactive.
- R10: With pass-through set, the pin equals the source clock: high in the high phase and low in the low phase, regardless of enable, gate and divider.
- R11: The two channels run independently, each from its own lane and its own period word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock; also the pass-through signal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i |
| pwm_o | output | NCH | One modulated pin per channel |

## Verification
The hardest situations to reach are writes that arrive in the middle of a running cycle. One is a divider code written while the gate is on, which must stay dormant until the gate drops. The other is a period or active-count write, which must wait for the cycle boundary. The stimulus issues these writes at arbitrary phases of a running cycle, toggles the gate around them, and compares every pin on every clock against a phase-counting model. That model tracks the elapsed source clocks in the cycle, not a divided counter. The pass-through case is also checked in the low half of each clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PSC_W  = 4;
  localparam int LANE_W = PSC_W + 4;

  // one channel lane of the shared control word, MSB first
  typedef struct packed {
    logic             byp;
    logic             gate;
    logic             pol;
    logic             en;
    logic [PSC_W-1:0] psc;
  } chan_ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic [NCH*LANE_W-1:0]             ctrl_o,
  output logic [NCH-1:0][2*CNT_W-1:0]       pd_o
);
  localparam int CTRL_W = NCH * LANE_W;
  localparam int PD_W   = 2 * CNT_W;

  logic [CTRL_W-1:0]         ctrl_q;
  logic [NCH-1:0][PD_W-1:0]  pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && addr_i == '0) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_pd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pd_q[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g + 1)) pd_q[g] <= wdata_i[PD_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o[CTRL_W-1:0] = ctrl_q;
    for (int i = 0; i < NCH; i++)
      if (addr_i == ADDR_W'(i + 1)) rdata_o[PD_W-1:0] = pd_q[i];
  end

  assign ctrl_o = ctrl_q;
  assign pd_o   = pd_q;

  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0) |=> ctrl_q == $past(wdata_i[CTRL_W-1:0])); // R2
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  chan_ctrl_t       cfg_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] dut_i,
  output logic             pin_o
);
  localparam int HALF  = 1 << (PSC_W - 1);
  localparam int DIV_W = HALF + 1;

  logic [PSC_W-1:0] hold_q, psc_eff;
  logic [DIV_W-1:0] div, pcnt_q;
  logic [CNT_W-1:0] cnt_q, per_a, dut_a;
  logic             out_q, run, tick, last, wrap, act;

  // divider code is frozen while the gate is on
  assign psc_eff = cfg_i.gate ? hold_q : cfg_i.psc;

  always_comb begin
    div = '0;
    if (&psc_eff)                div = DIV_W'(1);
    else if (!psc_eff[PSC_W-1])  div = DIV_W'(2) << psc_eff;
  end

  assign run  = cfg_i.en && cfg_i.gate && (div != '0);
  assign tick = (pcnt_q == div - DIV_W'(1));
  assign last = ((CNT_W + 1)'(cnt_q) + (CNT_W + 1)'(1)) >= (CNT_W + 1)'(per_a);
  assign wrap = tick && last;
  assign act  = (dut_a >= per_a) || (cnt_q < dut_a);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pcnt_q <= '0;
      cnt_q  <= '0;
      per_a  <= '0;
      dut_a  <= '0;
      out_q  <= 1'b1;
    end else begin
      hold_q <= psc_eff;
      if (!run) begin
        pcnt_q <= '0;
        cnt_q  <= '0;
        per_a  <= per_i;
        dut_a  <= dut_i;
        out_q  <= ~cfg_i.pol;
      end else begin
        out_q <= cfg_i.pol ? act : ~act;
        if (tick) begin
          pcnt_q <= '0;
          if (last) begin
            cnt_q <= '0;
            per_a <= per_i;
            dut_a <= dut_i;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end else begin
          pcnt_q <= pcnt_q + DIV_W'(1);
        end
      end
    end
  end

  assign pin_o = cfg_i.byp ? clk_i : out_q;

  AST_PSC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.gate && $past(cfg_i.gate)) |-> $stable(psc_eff)); // R7
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && per_a != '0) |-> cnt_q < per_a); // R3
  AST_PCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> pcnt_q < div); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wrap) |=> ($stable(per_a) && $stable(dut_a))); // R8
  AST_FULL_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && dut_a >= per_a) |=> out_q == $past(cfg_i.pol)); // R9
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  localparam int CTRL_W = NCH * LANE_W;

  logic [CTRL_W-1:0]            ctrl;
  logic [NCH-1:0][2*CNT_W-1:0]  pd;

  pwm_regs #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .ctrl_o  (ctrl),
    .pd_o    (pd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_ctrl_t cfg;
    assign cfg = chan_ctrl_t'(ctrl[g*LANE_W +: LANE_W]);

    pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg),
      .per_i  (pd[g][2*CNT_W-1:CNT_W]),
      .dut_i  (pd[g][CNT_W-1:0]),
      .pin_o  (pwm_o[g])
    );
  end
endmodule

// File: tb/pwm_multi_test.sv
module pwm_multi_test;
  localparam int NCH = 2;
  localparam int AW  = 2;
  localparam int DW  = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] pins;

  always #4 clk = ~clk;

  pwm_multi #(.NCH(NCH), .CNT_W(16), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pins)
  );

  int    n_cmp = 0, n_bad = 0;
  string req = "R1";
  bit    done = 0;

  // behavioural reference: register mirror plus elapsed-clock phase per channel
  logic [15:0] m_ctrl;
  logic [31:0] m_pd [NCH];
  logic [3:0]  hold [NCH];
  int          ph [NCH], pa [NCH], da [NCH];
  logic        exp_q [NCH];

  function automatic int div_of(logic [3:0] c);
    if (c == 4'd15) return 1;
    if (c < 4'd8)   return 2 << c;
    return 0;
  endfunction

  function automatic logic [7:0] lane(int code, bit en, bit pol, bit gate, bit byp);
    return {byp, gate, pol, en, 4'(code)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0;
      for (int c = 0; c < NCH; c++) begin
        m_pd[c] = '0; hold[c] = '0; ph[c] = 0; pa[c] = 0; da[c] = 0; exp_q[c] = 1'b1;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        logic [7:0] ln;
        logic [3:0] eff;
        int d;
        bit running, a;
        ln  = m_ctrl[c*8 +: 8];
        eff = ln[6] ? hold[c] : ln[3:0];
        hold[c] = eff;
        d = div_of(eff);
        running = ln[4] && ln[6] && (d != 0);
        if (!running) begin
          ph[c] = 0; pa[c] = int'(m_pd[c][31:16]); da[c] = int'(m_pd[c][15:0]);
          exp_q[c] = ~ln[5];
        end else begin
          a = (da[c] >= pa[c]) || (ph[c] < d * da[c]);
          exp_q[c] = ln[5] ? a : !a;
          ph[c]++;
          if (ph[c] >= d * ((pa[c] == 0) ? 1 : pa[c])) begin
            ph[c] = 0; pa[c] = int'(m_pd[c][31:16]); da[c] = int'(m_pd[c][15:0]);
          end
        end
      end
      if (we) begin
        if (addr == 2'd0) m_ctrl = wdata[15:0];
        else if (addr == 2'd1) m_pd[0] = wdata;
        else if (addr == 2'd2) m_pd[1] = wdata;
      end
    end
  end

  // high-phase comparison of every pin and of the read port
  always @(posedge clk) begin
    logic [31:0] exp_rd;
    #2;
    if (!done) begin
      for (int c = 0; c < NCH; c++) begin
        logic e;
        e = m_ctrl[c*8+7] ? 1'b1 : exp_q[c];
        n_cmp++;
        if (pins[c] !== e) begin
          n_bad++;
          $display("FAIL %s pin%0d got %b expected %b at %0t", req, c, pins[c], e, $time);
        end
      end
      case (addr)
        2'd0:    exp_rd = {16'h0, m_ctrl};
        2'd1:    exp_rd = m_pd[0];
        2'd2:    exp_rd = m_pd[1];
        default: exp_rd = '0;
      endcase
      n_cmp++;
      if (rdata !== exp_rd) begin
        n_bad++;
        $display("FAIL %s R2 readback addr %0d got %h expected %h", req, addr, rdata, exp_rd);
      end
    end
  end

  // low-phase check for pass-through channels (R10)
  always @(negedge clk) begin
    #2;
    if (!done && rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (m_ctrl[c*8+7]) begin
          n_cmp++;
          if (pins[c] !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 low phase pin%0d got %b expected 0", c, pins[c]);
          end
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog expired in %s", req);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    req = "R1";
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    idle(3);
    addr = 2'd3; idle(2);

    req = "R2";
    wr(2'd1, {16'd5, 16'd2});
    wr(2'd2, {16'd3, 16'd1});
    addr = 2'd1; idle(2);
    addr = 2'd3; idle(2);

    req = "R3 R5 R11";          // ch0 div1 normal sense, ch1 div4 inverted
    wr(2'd0, {lane(1, 1, 0, 1, 0), lane(15, 1, 1, 1, 0)});
    idle(40);

    req = "R8";                 // mid-cycle period/active change
    wr(2'd1, {16'd4, 16'd3});
    idle(3);
    wr(2'd2, {16'd2, 16'd1});
    idle(30);

    req = "R7";                 // divider write while gated on
    wr(2'd0, {lane(1, 1, 0, 1, 0), lane(0, 1, 1, 1, 0)});
    idle(20);
    wr(2'd0, {lane(1, 1, 0, 1, 0), lane(0, 1, 1, 0, 0)});
    idle(3);
    wr(2'd0, {lane(1, 1, 0, 1, 0), lane(0, 1, 1, 1, 0)});
    idle(30);

    req = "R9";
    wr(2'd1, {16'd4, 16'd0});
    idle(25);
    wr(2'd1, {16'd3, 16'd3});
    idle(25);
    wr(2'd1, {16'd2, 16'd9});
    idle(15);

    req = "R4";                 // invalid code, then code 15 again
    wr(2'd0, {lane(1, 1, 0, 1, 0), lane(9, 1, 1, 0, 0)});
    wr(2'd0, {lane(1, 1, 0, 1, 0), lane(9, 1, 1, 1, 0)});
    wr(2'd1, {16'd3, 16'd1});
    idle(20);
    wr(2'd0, {lane(1, 1, 0, 1, 0), lane(15, 1, 1, 0, 0)});
    wr(2'd0, {lane(1, 1, 0, 1, 0), lane(15, 1, 1, 1, 0)});
    idle(15);

    req = "R6";
    wr(2'd0, {lane(1, 1, 0, 1, 0), lane(15, 0, 1, 1, 0)});
    idle(10);
    wr(2'd0, {lane(1, 1, 0, 1, 0), lane(15, 1, 1, 0, 0)});
    idle(10);
    wr(2'd0, {lane(1, 1, 0, 1, 0), lane(15, 1, 1, 1, 0)});
    idle(20);

    req = "R10";                // pass-through on ch1 with enable and gate off
    wr(2'd0, {lane(9, 0, 0, 0, 1), lane(15, 1, 1, 1, 0)});
    idle(15);
    wr(2'd0, {lane(1, 1, 0, 1, 1), lane(15, 1, 1, 1, 0)});
    idle(10);
    wr(2'd0, {lane(1, 1, 0, 1, 0), lane(15, 1, 1, 1, 0)});
    idle(20);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule